// File: doc/BRIEF.md
# Linear CCD Line Readout Timing Generator

This block drives a linear CCD image sensor from a fast system clock. Each line opens with a setup interval. A transfer gate pulse follows, then a hold interval, then a fixed run of 4034 pixel shift-clock slots. Every width and guard interval is a count of system-clock ticks. The counts are supplied on input ports and captured at the start of each line, so software may change them at any time and the change shows up on the next line.

While a slot is in progress the block reports the slot number and a class code that marks the slot as dummy, optical black or effective. It also raises a one-tick sample strobe at a programmable delay after the shift clock's rising edge, which gives the downstream converter time for the sensor's output delay. A 2-bit mode selects one of three reset arrangements: internal reset, internal reset with sample-hold, or an active-low reset pulse that the block generates once per slot.

Line generation runs freely while `enable` is high. When `enable` drops, the line in progress runs to its end and the outputs then go idle.

Top module: `ccd_line_timer`

## Requirements
- R1: After `line_start_o`, a line consists of the following phases in order. Setup lasts S ticks with `rog_o` and `ccd_clk_o` both low. `rog_o` is then high for R ticks. Hold lasts H ticks with both low. Then come 4034 slots; in each, `ccd_clk_o` is high for HI ticks and then low for LO ticks. If `enable` is high in the last tick of slot 4034, the next line starts on the following tick.
- R2: `pix_class_o` is 0 (dummy) for slots 1-18 and 4017-4034. It is 1 (optical black) for slots 19-98 and 2 (effective) for slots 99-4016.
- R3: During a slot, `pix_idx_o` holds the slot number 1..4034. Outside the pixel phase it is 0, and `pix_class_o` is then 0.
- R4: `rog_o` and `ccd_clk_o` are never high in the same tick.
- R5: `line_start_o` is a one-tick pulse in the first setup tick. From idle it follows the first tick in which `enable` is seen high.
- R6: `sample_o` is high for exactly one tick per slot, at tick SMP counted from 0 at the slot's first tick. If SMP is not below HI+LO, there is no strobe.
- R7: With mode 2, `rs_n_o` is low in slot ticks OFF through OFF+LEN-1, cut off at the slot end. With modes 0, 1 and 3 it stays high.
- R8: `sh_en_o` is high exactly when the mode captured for the current or most recent line is 1.
- R9: All tick counts and the mode are captured at `line_start_o`. Changing them mid-line does not alter the line in progress.
- R10: When `enable` goes low mid-line, the current line completes. After that, outputs stay idle and no `line_start_o` occurs.
- R11: A value of 0 for S, R, H, HI, LO or LEN acts as 1.
- R12: During and right after reset, the outputs are as follows: `rog_o`, `ccd_clk_o`, `sample_o`, `line_start_o` and `sh_en_o` are 0, `rs_n_o` is 1, and index and class are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run free-running line generation |
| rs_mode | input | 2 | 0 internal reset, 1 internal reset with sample-hold, 2 external reset pulses, 3 as 0 |
| setup_ticks | input | TW | S: clock idle ticks before the gate pulse |
| rog_ticks | input | TW | R: gate pulse high ticks |
| hold_ticks | input | TW | H: idle ticks after the gate pulse |
| clk_hi_ticks | input | TW | HI: shift clock high ticks |
| clk_lo_ticks | input | TW | LO: shift clock low ticks |
| rs_off_ticks | input | TW | OFF: reset pulse offset in the slot |
| rs_len_ticks | input | TW | LEN: reset pulse low ticks |
| smp_dly_ticks | input | TW | SMP: sample strobe offset in the slot |
| rog_o | output | 1 | Transfer gate pulse |
| ccd_clk_o | output | 1 | Pixel shift clock |
| rs_n_o | output | 1 | Active-low reset pulse |
| sh_en_o | output | 1 | Sample-hold select level |
| line_start_o | output | 1 | First tick of a line |
| sample_o | output | 1 | Converter sample strobe |
| pix_idx_o | output | IDX_W | Current slot number, 0 when not in a slot |
| pix_class_o | output | 2 | Slot class code |

## Verification
Two pairs of events can land in the same tick. First, the sample strobe and the reset pulse: an offset of 0 places the strobe on the slot's rising clock tick, and the reset window is placed so that it covers that same tick. Second, the end of the last slot and the next `line_start_o`. A bench reference model, built from tick arithmetic over the time since line start, predicts every output in every tick, and each coincident tick is judged against it. The bench also measures each line length from one `line_start_o` to the next, and it changes the inputs mid-line to confirm they are captured per line.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_ROG   = 3'd2,
        ST_HOLD  = 3'd3,
        ST_PIX   = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        CLS_DUMMY = 2'd0,
        CLS_OB    = 2'd1,
        CLS_EFF   = 2'd2
    } pix_class_e;

    typedef enum logic [1:0] {
        MD_INT    = 2'd0,
        MD_INT_SH = 2'd1,
        MD_EXT    = 2'd2,
        MD_RSV    = 2'd3
    } rs_mode_e;
endpackage

// File: rtl/ccd_slot_class.sv
module ccd_slot_class #(
    parameter int IDX_W        = 12,
    parameter int LEAD_DUMMY   = 18,
    parameter int OB_SLOTS     = 80,
    parameter int ACTIVE_SLOTS = 3918
) (
    input  logic [IDX_W-1:0] idx,
    output logic [1:0]       cls
);
    import ccd_pkg::*;
    localparam int OB_FIRST  = LEAD_DUMMY + 1;
    localparam int OB_LAST   = LEAD_DUMMY + OB_SLOTS;
    localparam int EFF_FIRST = OB_LAST + 1;
    localparam int EFF_LAST  = OB_LAST + ACTIVE_SLOTS;

    always_comb begin
        cls = CLS_DUMMY;
        if (int'(idx) >= OB_FIRST && int'(idx) <= OB_LAST)
            cls = CLS_OB;
        else if (int'(idx) >= EFF_FIRST && int'(idx) <= EFF_LAST)
            cls = CLS_EFF;
    end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
    import ccd_pkg::*;
#(
    parameter int TW           = 8,
    parameter int IDX_W        = 12,
    parameter int LEAD_DUMMY   = 18,
    parameter int OB_SLOTS     = 80,
    parameter int ACTIVE_SLOTS = 3918,
    parameter int TRAIL_DUMMY  = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       rs_mode,
    input  logic [TW-1:0]    setup_ticks,
    input  logic [TW-1:0]    rog_ticks,
    input  logic [TW-1:0]    hold_ticks,
    input  logic [TW-1:0]    clk_hi_ticks,
    input  logic [TW-1:0]    clk_lo_ticks,
    input  logic [TW-1:0]    rs_off_ticks,
    input  logic [TW-1:0]    rs_len_ticks,
    input  logic [TW-1:0]    smp_dly_ticks,
    output logic             rog_o,
    output logic             ccd_clk_o,
    output logic             rs_n_o,
    output logic             sh_en_o,
    output logic             line_start_o,
    output logic             sample_o,
    output logic [IDX_W-1:0] pix_idx_o,
    output logic [1:0]       pix_class_o
);
    localparam int LINE_SLOTS = LEAD_DUMMY + OB_SLOTS + ACTIVE_SLOTS + TRAIL_DUMMY;
    localparam int CW         = TW + 1;

    typedef struct packed {
        logic [1:0]    mode;
        logic [TW-1:0] setup;
        logic [TW-1:0] rog;
        logic [TW-1:0] hold;
        logic [TW-1:0] hi;
        logic [TW-1:0] lo;
        logic [TW-1:0] rs_off;
        logic [TW-1:0] rs_len;
        logic [TW-1:0] smp;
    } cfg_t;

    typedef struct packed {
        phase_e           st;
        logic [CW-1:0]    tk;
        logic [IDX_W-1:0] slot;
        logic             ls;
        cfg_t             cfg;
    } reg_t;

    reg_t q, d;
    cfg_t cfg_in;

    // zero counts behave as one tick (R11)
    function automatic logic [TW-1:0] min1(input logic [TW-1:0] v);
        return (v == '0) ? TW'(1) : v;
    endfunction

    always_comb begin
        cfg_in.mode   = rs_mode;
        cfg_in.setup  = min1(setup_ticks);
        cfg_in.rog    = min1(rog_ticks);
        cfg_in.hold   = min1(hold_ticks);
        cfg_in.hi     = min1(clk_hi_ticks);
        cfg_in.lo     = min1(clk_lo_ticks);
        cfg_in.rs_off = rs_off_ticks;
        cfg_in.rs_len = min1(rs_len_ticks);
        cfg_in.smp    = smp_dly_ticks;
    end

    logic [CW-1:0] last_setup, last_rog, last_hold, last_slot_tk;
    logic [CW-1:0] rs_lo_edge, rs_hi_edge;
    logic          slot_end, line_end;

    assign last_setup   = CW'(q.cfg.setup) - CW'(1);
    assign last_rog     = CW'(q.cfg.rog) - CW'(1);
    assign last_hold    = CW'(q.cfg.hold) - CW'(1);
    assign last_slot_tk = CW'(q.cfg.hi) + CW'(q.cfg.lo) - CW'(1);
    assign rs_lo_edge   = CW'(q.cfg.rs_off);
    assign rs_hi_edge   = CW'(q.cfg.rs_off) + CW'(q.cfg.rs_len);
    assign slot_end     = (q.tk == last_slot_tk);
    assign line_end     = (q.slot == IDX_W'(LINE_SLOTS));

    always_comb begin
        d    = q;
        d.ls = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (enable) begin
                    d.st  = ST_SETUP;
                    d.tk  = '0;
                    d.cfg = cfg_in;
                    d.ls  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (q.tk == last_setup) begin
                    d.st = ST_ROG;
                    d.tk = '0;
                end else begin
                    d.tk = q.tk + CW'(1);
                end
            end
            ST_ROG: begin
                if (q.tk == last_rog) begin
                    d.st = ST_HOLD;
                    d.tk = '0;
                end else begin
                    d.tk = q.tk + CW'(1);
                end
            end
            ST_HOLD: begin
                if (q.tk == last_hold) begin
                    d.st   = ST_PIX;
                    d.tk   = '0;
                    d.slot = IDX_W'(1);
                end else begin
                    d.tk = q.tk + CW'(1);
                end
            end
            ST_PIX: begin
                if (slot_end) begin
                    d.tk = '0;
                    if (line_end) begin
                        d.slot = '0;
                        if (enable) begin
                            d.st  = ST_SETUP;
                            d.cfg = cfg_in;
                            d.ls  = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.slot = q.slot + IDX_W'(1);
                    end
                end else begin
                    d.tk = q.tk + CW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic in_pix;
    assign in_pix       = (q.st == ST_PIX);
    assign rog_o        = (q.st == ST_ROG);
    assign ccd_clk_o    = in_pix && (q.tk < CW'(q.cfg.hi));
    assign line_start_o = q.ls;
    assign sample_o     = in_pix && (q.tk == CW'(q.cfg.smp));
    assign rs_n_o       = !(in_pix && (q.cfg.mode == MD_EXT) &&
                            (q.tk >= rs_lo_edge) && (q.tk < rs_hi_edge));
    assign sh_en_o      = (q.cfg.mode == MD_INT_SH);
    assign pix_idx_o    = in_pix ? q.slot : '0;

    ccd_slot_class #(
        .IDX_W        (IDX_W),
        .LEAD_DUMMY   (LEAD_DUMMY),
        .OB_SLOTS     (OB_SLOTS),
        .ACTIVE_SLOTS (ACTIVE_SLOTS)
    ) u_class (
        .idx (pix_idx_o),
        .cls (pix_class_o)
    );
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
    parameter int IDX_W        = 12,
    parameter int LEAD_DUMMY   = 18,
    parameter int OB_SLOTS     = 80,
    parameter int ACTIVE_SLOTS = 3918,
    parameter int TRAIL_DUMMY  = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rog_o,
    input logic             ccd_clk_o,
    input logic             rs_n_o,
    input logic             sh_en_o,
    input logic             line_start_o,
    input logic             sample_o,
    input logic [IDX_W-1:0] pix_idx_o,
    input logic [1:0]       pix_class_o
);
    localparam int LAST_SLOT = LEAD_DUMMY + OB_SLOTS + ACTIVE_SLOTS + TRAIL_DUMMY;
    localparam int EFF_FIRST = LEAD_DUMMY + OB_SLOTS + 1;
    localparam int EFF_LAST  = LEAD_DUMMY + OB_SLOTS + ACTIVE_SLOTS;

    AST_GATE_CLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rog_o && ccd_clk_o)); // R4
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pix_idx_o) <= LAST_SLOT); // R3
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(pix_idx_o) && pix_idx_o != '0 && $past(pix_idx_o) != '0)
        |-> pix_idx_o == $past(pix_idx_o) + IDX_W'(1)); // R1
    AST_EFF_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pix_idx_o) >= EFF_FIRST && int'(pix_idx_o) <= EFF_LAST)
        |-> pix_class_o == 2'd2); // R2
    AST_IDLE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_idx_o == '0 |-> pix_class_o == 2'd0); // R3
    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |-> (pix_idx_o == '0 && !rog_o && !ccd_clk_o)); // R5
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_start_o |=> !line_start_o); // R5
    AST_STROBE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> pix_idx_o != '0); // R6
    AST_RS_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_n_o |-> pix_idx_o != '0); // R7
    AST_RS_NOT_SH: assert property (@(posedge clk) disable iff (!rst_n)
        sh_en_o |-> rs_n_o); // R7
endmodule

bind ccd_line_timer ccd_line_timer_chk #(
    .IDX_W        (IDX_W),
    .LEAD_DUMMY   (LEAD_DUMMY),
    .OB_SLOTS     (OB_SLOTS),
    .ACTIVE_SLOTS (ACTIVE_SLOTS),
    .TRAIL_DUMMY  (TRAIL_DUMMY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rog_o        (rog_o),
    .ccd_clk_o    (ccd_clk_o),
    .rs_n_o       (rs_n_o),
    .sh_en_o      (sh_en_o),
    .line_start_o (line_start_o),
    .sample_o     (sample_o),
    .pix_idx_o    (pix_idx_o),
    .pix_class_o  (pix_class_o)
);

// File: tb/sim_ccd_line_timer.sv
`timescale 1ns/1ps
module sim_ccd_line_timer;
    localparam int TW    = 8;
    localparam int IDX_W = 12;
    localparam int SLOTS = 4034;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [1:0] rs_mode = 2'd0;
    logic [TW-1:0] setup_ticks = '0, rog_ticks = '0, hold_ticks = '0;
    logic [TW-1:0] clk_hi_ticks = '0, clk_lo_ticks = '0;
    logic [TW-1:0] rs_off_ticks = '0, rs_len_ticks = '0, smp_dly_ticks = '0;
    logic rog_o, ccd_clk_o, rs_n_o, sh_en_o, line_start_o, sample_o;
    logic [IDX_W-1:0] pix_idx_o;
    logic [1:0] pix_class_o;

    always #4 clk = ~clk;

    ccd_line_timer u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rs_mode(rs_mode),
        .setup_ticks(setup_ticks), .rog_ticks(rog_ticks), .hold_ticks(hold_ticks),
        .clk_hi_ticks(clk_hi_ticks), .clk_lo_ticks(clk_lo_ticks),
        .rs_off_ticks(rs_off_ticks), .rs_len_ticks(rs_len_ticks),
        .smp_dly_ticks(smp_dly_ticks),
        .rog_o(rog_o), .ccd_clk_o(ccd_clk_o), .rs_n_o(rs_n_o), .sh_en_o(sh_en_o),
        .line_start_o(line_start_o), .sample_o(sample_o),
        .pix_idx_o(pix_idx_o), .pix_class_o(pix_class_o)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int one_min(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // behavioural reference: time since line start plus captured settings
    int m_on = 0, m_t = 0, m_mode = 0;
    int m_s, m_r, m_h, m_hi, m_lo, m_off, m_len, m_smp, m_len_line;

    function automatic int line_len();
        return m_s + m_r + m_h + SLOTS * (m_hi + m_lo);
    endfunction

    task automatic capture();
        m_on = 1; m_t = 0; m_mode = int'(rs_mode);
        m_s = one_min(setup_ticks); m_r = one_min(rog_ticks); m_h = one_min(hold_ticks);
        m_hi = one_min(clk_hi_ticks); m_lo = one_min(clk_lo_ticks);
        m_off = int'(rs_off_ticks); m_len = one_min(rs_len_ticks); m_smp = int'(smp_dly_ticks);
        m_len_line = line_len();
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_on = 0; m_t = 0; m_mode = 0;
        end else if (m_on == 0) begin
            if (enable) capture();
        end else if (m_t == m_len_line - 1) begin
            if (enable) capture();
            else m_on = 0;
        end else begin
            m_t++;
        end
    end

    int cyc = 0, ls_count = 0, last_ls = -1, prev_len = 0;

    always @(negedge clk) begin
        int e_rog, e_clk, e_rs, e_ls, e_smp, e_idx, e_cls, p, ph, per, base;
        cyc++;
        if (rst_n) begin
            e_rog = 0; e_clk = 0; e_rs = 1; e_ls = 0; e_smp = 0; e_idx = 0; e_cls = 0;
            if (m_on != 0) begin
                base = m_s + m_r + m_h;
                per  = m_hi + m_lo;
                e_ls = (m_t == 0);
                if (m_t >= m_s && m_t < m_s + m_r) e_rog = 1;
                if (m_t >= base) begin
                    p = m_t - base;
                    e_idx = p / per + 1;
                    ph = p % per;
                    e_clk = (ph < m_hi);
                    e_smp = (ph == m_smp);
                    if (m_mode == 2 && ph >= m_off && ph < m_off + m_len) e_rs = 0;
                    if (e_idx >= 19 && e_idx <= 98) e_cls = 1;
                    else if (e_idx >= 99 && e_idx <= 4016) e_cls = 2;
                end
            end
            chk(rog_o == e_rog, "R1 rog", rog_o, e_rog);
            chk(ccd_clk_o == e_clk, "R1 ccd_clk", ccd_clk_o, e_clk);
            chk(!(rog_o && ccd_clk_o), "R4 overlap", 1, 0);
            chk(int'(pix_idx_o) == e_idx, "R3 index", pix_idx_o, e_idx);
            chk(int'(pix_class_o) == e_cls, "R2 class", pix_class_o, e_cls);
            chk(sample_o == e_smp, "R6 strobe", sample_o, e_smp);
            chk(rs_n_o == e_rs, "R7 rs_n", rs_n_o, e_rs);
            chk(sh_en_o == (m_mode == 1), "R8 sh_en", sh_en_o, m_mode == 1);
            chk(line_start_o == e_ls, "R5 line_start", line_start_o, e_ls);
            if (line_start_o) begin
                if (last_ls >= 0)
                    chk(cyc - last_ls == prev_len, "R9 R11 line length", cyc - last_ls, prev_len);
                last_ls = cyc;
                prev_len = m_len_line;
                ls_count++;
            end
        end
    end

    task automatic set_cfg(input int md, input int s, input int r, input int h,
                           input int hi, input int lo, input int off, input int len,
                           input int smp);
        rs_mode = 2'(md); setup_ticks = TW'(s); rog_ticks = TW'(r); hold_ticks = TW'(h);
        clk_hi_ticks = TW'(hi); clk_lo_ticks = TW'(lo);
        rs_off_ticks = TW'(off); rs_len_ticks = TW'(len); smp_dly_ticks = TW'(smp);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        // line A: external reset, strobe on rising tick overlapping the reset window
        set_cfg(2, 3, 5, 2, 2, 2, 0, 2, 0);
        repeat (3) @(negedge clk);
        // R12 reset state while held in reset
        chk(rog_o == 0 && ccd_clk_o == 0 && sample_o == 0 && line_start_o == 0,
            "R12 pulses", {rog_o, ccd_clk_o, sample_o, line_start_o}, 0);
        chk(rs_n_o == 1 && sh_en_o == 0, "R12 rs/sh", {rs_n_o, sh_en_o}, 2);
        chk(pix_idx_o == 0 && pix_class_o == 0, "R12 idx/class", pix_idx_o, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(line_start_o == 0 && pix_idx_o == 0, "R12 idle after reset", line_start_o, 0);
        enable = 1'b1;
        wait (ls_count == 1);
        repeat (5000) @(negedge clk);
        // mid-line change: must not affect line A (R9); zero counts clamp (R11)
        set_cfg(0, 0, 1, 1, 1, 1, 0, 0, 1);
        wait (ls_count == 2);
        repeat (100) @(negedge clk);
        // line C: sample-hold mode, strobe offset beyond slot (no strobe, R6)
        set_cfg(1, 2, 4, 3, 1, 2, 0, 1, 5);
        wait (ls_count == 3);
        repeat (3000) @(negedge clk);
        enable = 1'b0;   // R10: current line must run to completion
        wait (m_on == 0);
        repeat (40) begin
            @(negedge clk);
            chk(pix_idx_o == 0 && !rog_o && !ccd_clk_o, "R10 idle outputs", pix_idx_o, 0);
        end
        chk(ls_count == 3, "R10 no further line", ls_count, 3);
        finish_run();
    end
endmodule